// File: doc/BRIEF.md
# Video Engine Control and Status Register Block

This block is the software-facing register file that sits beside a streaming video depacketizing engine. It is an AXI4-Lite slave with an 8-bit byte address and 32-bit data. Through it, software programs the geometry of the incoming video (active width, line count, sample format, packets per line, regular and final payload lengths, bits per component) and runs the engine with a start / done / idle / ready protocol. It also reads back a received-packet statistic.

To bring the engine up, software clears the control word, programs the geometry, sets the auto-restart bit and then sets the start bit. Start drops when the engine signals ready while start is high. With auto-restart set, start is raised again at once, so the engine keeps running without further writes. A completion pulse from the engine is latched as a done flag that the next read of the control word consumes. There is no soft reset: only the hardware reset returns everything to zero.

Top module: `vid_ctrl_regs`

## Requirements
- R1: After the synchronous reset (`rst` high), every register reads zero, `eng_start`, `eng_autorestart` and `stat_clear` are 0, every configuration output is 0, `bvalid` and `rvalid` are 0, and `awready`, `wready` and `arready` are 1.
- R2: The write address and the write data may be accepted in either order or together. `awready` is high only while no address is held and no response is pending. `wready` follows the same rule for data. The write takes effect at the clock edge after both halves are held, and `bvalid` rises at that same edge. `bvalid` stays high with `bresp` = 0 (OKAY) until `bready` is seen.
- R3: The configuration registers read back what was written, with every bit outside the field reading 0, and they drive their outputs. The fields are: width at 0x10 bits 15:0, height at 0x18 bits 15:0, format at 0x20 bits 15:0 (0 RGB, 1 4:4:4, 2 4:2:2, 3 4:2:0), packets per line at 0x28 bits 7:0, payload length at 0x30 bits 10:0, last payload length at 0x38 bits 10:0, and bits per component at 0x40 bits 4:0.
- R4: Write strobe bit n enables data byte n (bits 8n+7:8n). A byte whose strobe is low keeps its old value.
- R5: In the control word at 0x00, bit 0 is start and bit 7 is auto-restart. A write with strobe 0 set loads both bits, and they appear on `eng_start` and `eng_autorestart` at the edge where the write takes effect.
- R6: When `eng_start` and `eng_ready` are both high at an edge and auto-restart is 0, start clears at that edge.
- R7: When auto-restart is 1, the same handshake leaves start at 1. A control write in the same cycle takes precedence over the handshake.
- R8: An `eng_done` pulse sets control bit 1. The first read of 0x00 returns it as 1 and clears it. A new pulse in the same cycle as that read keeps it set.
- R9: Control bits 2 and 3 return the `eng_idle` and `eng_ready` inputs as they stand in the cycle the read address is accepted. Bits 6:4 and 31:8 read 0.
- R10: 0x48 returns the 32-bit `pkt_count` input. Bit 0 of 0x50 is set by a `pkt_count_upd` pulse and cleared by a read of 0x50, and the read returns the value it had before clearing.
- R11: Bit 0 of 0x54 drives `stat_clear` and stays set until software writes it to 0.
- R12: Writes to 0x00 with strobe 0 low, to the read-only addresses 0x48 and 0x50, or to unmapped addresses change nothing. Unmapped addresses read 0, and every read has `rresp` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_start | output | 1 | Run request to the engine |
| eng_autorestart | output | 1 | Continuous-run mode to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_idle | input | 1 | Engine idle level |
| eng_ready | input | 1 | Engine ready to take a start |
| pkt_count | input | 32 | Received-packet count from the engine |
| pkt_count_upd | input | 1 | Pulse marking a fresh packet count |
| cfg_width | output | 16 | Active pixels per line |
| cfg_height | output | 16 | Active lines per frame or field |
| cfg_format | output | 16 | Sample format code |
| cfg_pkts_per_line | output | 8 | Packets per video line |
| cfg_payload_len | output | 11 | Payload bytes in a regular packet |
| cfg_payload_last | output | 11 | Payload bytes in the final packet of a line |
| cfg_bpc | output | 5 | Bits per component |
| stat_clear | output | 1 | Statistics reset level |

## Verification
A wrong held-address or pending-response flag shows on `s_awready`, `s_wready` or `s_bvalid` in the cycle right after the faulty edge. The bench's cycle model compares these flags on every clock, so such a fault is caught within one cycle. A start bit that does not clear on the handshake, or that fails to rearm under auto-restart, shows on `eng_start` one cycle after the `eng_ready` pulse. A done or count-valid flag that is lost or does not clear only shows on the next read of its address. The bench therefore reads those addresses twice in a row, around each engine pulse.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int NCFG   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_PKTCNT = 8'h48;
  localparam logic [ADDR_W-1:0] A_CNTVLD = 8'h50;

  // bit positions inside the control word
  localparam int B_START = 0;
  localparam int B_DONE  = 1;
  localparam int B_IDLE  = 2;
  localparam int B_READY = 3;
  localparam int B_AUTO  = 7;

  // configuration slots: 0 width, 1 height, 2 format, 3 packets/line,
  // 4 payload, 5 last payload, 6 bits/component, 7 stats clear
  function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
    case (idx)
      0: return 8'h10;
      1: return 8'h18;
      2: return 8'h20;
      3: return 8'h28;
      4: return 8'h30;
      5: return 8'h38;
      6: return 8'h40;
      default: return 8'h54;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cfg_mask(input int idx);
    case (idx)
      0, 1, 2: return 32'h0000_FFFF;
      3:       return 32'h0000_00FF;
      4, 5:    return 32'h0000_07FF;
      6:       return 32'h0000_001F;
      default: return 32'h0000_0001;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] strb_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] res;
    res = old_v;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/vcr_axil_wr.sv
module vcr_axil_wr
  import vcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_held, w_held;

  assign awready = !aw_held && !bvalid;
  assign wready  = !w_held && !bvalid;
  assign wr_en   = aw_held && w_held && !bvalid;
  assign bresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      bvalid  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        wr_addr <= awaddr;
      end
      if (wvalid && wready) begin
        w_held  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
      if (wr_en) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcr_axil_rd.sv
module vcr_axil_rd
  import vcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_value
);
  assign arready = !rvalid;
  assign rd_en   = arvalid && arready;
  assign rd_addr = araddr;
  assign rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_en) begin
      rvalid <= 1'b1;
      rdata  <= rd_value;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/vcr_cfg_bank.sv
module vcr_cfg_bank
  import vcr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [STRB_W-1:0]             wr_strb,
  output logic [NCFG-1:0][DATA_W-1:0]   cfg_q
);
  for (genvar i = 0; i < NCFG; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = cfg_addr(i);
    localparam logic [DATA_W-1:0] SLOT_MASK = cfg_mask(i);
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[i] <= '0;
      else if (wr_en && wr_addr == SLOT_ADDR)
        cfg_q[i] <= strb_merge(cfg_q[i], wr_data, wr_strb) & SLOT_MASK;
    end
  end
endmodule

// File: rtl/vcr_run_ctrl.sv
module vcr_run_ctrl
  import vcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              eng_done,
  input  logic              eng_ready,
  input  logic              pkt_upd,
  output logic              start_q,
  output logic              auto_q,
  output logic              done_q,
  output logic              cnt_valid_q
);
  logic start_n;

  always_comb begin
    start_n = start_q;
    if (start_q && eng_ready) start_n = auto_q;
    if (ctrl_wr) start_n = wr_data[B_START];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q     <= 1'b0;
      auto_q      <= 1'b0;
      done_q      <= 1'b0;
      cnt_valid_q <= 1'b0;
    end else begin
      start_q <= start_n;
      if (ctrl_wr) auto_q <= wr_data[B_AUTO];
      if (eng_done)
        done_q <= 1'b1;
      else if (rd_en && rd_addr == A_CTRL)
        done_q <= 1'b0;
      if (pkt_upd)
        cnt_valid_q <= 1'b1;
      else if (rd_en && rd_addr == A_CNTVLD)
        cnt_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_ctrl_regs.sv
module vid_ctrl_regs
  import vcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              eng_start,
  output logic              eng_autorestart,
  input  logic              eng_done,
  input  logic              eng_idle,
  input  logic              eng_ready,
  input  logic [DATA_W-1:0] pkt_count,
  input  logic              pkt_count_upd,
  output logic [15:0]       cfg_width,
  output logic [15:0]       cfg_height,
  output logic [15:0]       cfg_format,
  output logic [7:0]        cfg_pkts_per_line,
  output logic [10:0]       cfg_payload_len,
  output logic [10:0]       cfg_payload_last,
  output logic [4:0]        cfg_bpc,
  output logic              stat_clear
);
  logic              wr_en, rd_en, ctrl_wr;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_value;
  logic [STRB_W-1:0] wr_strb;
  logic              done_q, cnt_valid_q;
  logic [NCFG-1:0][DATA_W-1:0] cfg_q;

  vcr_axil_wr u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  vcr_axil_rd u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_value(rd_value)
  );

  vcr_cfg_bank u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .cfg_q(cfg_q)
  );

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL) && wr_strb[0];

  vcr_run_ctrl u_run (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .eng_done(eng_done),
    .eng_ready(eng_ready), .pkt_upd(pkt_count_upd),
    .start_q(eng_start), .auto_q(eng_autorestart),
    .done_q(done_q), .cnt_valid_q(cnt_valid_q)
  );

  always_comb begin
    rd_value = '0;
    if (rd_addr == A_CTRL) begin
      rd_value[B_START] = eng_start;
      rd_value[B_DONE]  = done_q;
      rd_value[B_IDLE]  = eng_idle;
      rd_value[B_READY] = eng_ready;
      rd_value[B_AUTO]  = eng_autorestart;
    end else if (rd_addr == A_PKTCNT) begin
      rd_value = pkt_count;
    end else if (rd_addr == A_CNTVLD) begin
      rd_value[0] = cnt_valid_q;
    end else begin
      for (int i = 0; i < NCFG; i++)
        if (rd_addr == cfg_addr(i)) rd_value = cfg_q[i];
    end
  end

  assign cfg_width         = cfg_q[0][15:0];
  assign cfg_height        = cfg_q[1][15:0];
  assign cfg_format        = cfg_q[2][15:0];
  assign cfg_pkts_per_line = cfg_q[3][7:0];
  assign cfg_payload_len   = cfg_q[4][10:0];
  assign cfg_payload_last  = cfg_q[5][10:0];
  assign cfg_bpc           = cfg_q[6][4:0];
  assign stat_clear        = cfg_q[7][0];
endmodule

// File: rtl/vcr_regs_chk.sv
module vcr_regs_chk (
  input logic clk,
  input logic rst,
  input logic awready,
  input logic wready,
  input logic bvalid,
  input logic bready,
  input logic rvalid,
  input logic rready,
  input logic [31:0] rdata,
  input logic eng_start,
  input logic eng_autorestart,
  input logic eng_ready,
  input logic eng_done,
  input logic ctrl_wr,
  input logic done_q
);
  AST_BVALID_HELD: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid); // R2
  AST_NO_ACCEPT_WHILE_RESP: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !awready && !wready); // R2
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata)); // R12
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    eng_start && eng_ready && !eng_autorestart && !ctrl_wr |=> !eng_start); // R6
  AST_AUTO_REARM: assert property (@(posedge clk) disable iff (rst)
    eng_start && eng_ready && eng_autorestart && !ctrl_wr |=> eng_start); // R7
  AST_DONE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> done_q); // R8
endmodule

bind vid_ctrl_regs vcr_regs_chk u_chk (
  .clk(clk), .rst(rst), .awready(s_awready), .wready(s_wready),
  .bvalid(s_bvalid), .bready(s_bready), .rvalid(s_rvalid), .rready(s_rready),
  .rdata(s_rdata), .eng_start(eng_start), .eng_autorestart(eng_autorestart),
  .eng_ready(eng_ready), .eng_done(eng_done), .ctrl_wr(ctrl_wr), .done_q(done_q)
);

// File: tb/vid_ctrl_regs_tb.sv
module vid_ctrl_regs_tb;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        eng_start, eng_autorestart;
  logic        eng_done = 0, eng_idle = 0, eng_ready = 0, pkt_upd = 0;
  logic [31:0] pkt_count = '0;
  logic [15:0] cfg_width, cfg_height, cfg_format;
  logic [7:0]  cfg_ppl;
  logic [10:0] cfg_plen, cfg_plast;
  logic [4:0]  cfg_bpc;
  logic        stat_clear;

  vid_ctrl_regs u_dut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .eng_start(eng_start), .eng_autorestart(eng_autorestart),
    .eng_done(eng_done), .eng_idle(eng_idle), .eng_ready(eng_ready),
    .pkt_count(pkt_count), .pkt_count_upd(pkt_upd),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_format(cfg_format),
    .cfg_pkts_per_line(cfg_ppl), .cfg_payload_len(cfg_plen),
    .cfg_payload_last(cfg_plast), .cfg_bpc(cfg_bpc), .stat_clear(stat_clear)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mreg [int];
  bit          m_awf, m_wf, m_b, m_r, m_start, m_auto, m_done, m_vld;
  logic [7:0]  m_awa, m_ra;
  logic [31:0] m_wd, m_rd;
  logic [3:0]  m_ws;

  function automatic logic [31:0] fmask(logic [7:0] a);
    case (a)
      8'h10, 8'h18, 8'h20: return 32'hFFFF;
      8'h28: return 32'hFF;
      8'h30, 8'h38: return 32'h7FF;
      8'h40: return 32'h1F;
      8'h54: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mget(logic [7:0] a);
    return mreg.exists(int'(a)) ? mreg[int'(a)] : 32'h0;
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    if (a == 8'h00) return {24'h0, m_auto, 3'b000, eng_ready, eng_idle, m_done, m_start};
    if (a == 8'h48) return pkt_count;
    if (a == 8'h50) return {31'h0, m_vld};
    return mget(a) & fmask(a);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_awf = 0; m_wf = 0; m_b = 0; m_r = 0;
      m_start = 0; m_auto = 0; m_done = 0; m_vld = 0; m_rd = 0;
      mreg.delete();
    end else begin
      bit commit, awf, wf, arf;
      logic [31:0] nv;
      commit = m_awf && m_wf && !m_b;
      awf = awvalid && !m_awf && !m_b;
      wf  = wvalid && !m_wf && !m_b;
      arf = arvalid && !m_r;
      if (arf) begin m_rd = mread(araddr); m_ra = araddr; end
      if (m_start && eng_ready) m_start = m_auto;
      if (commit) begin
        if (m_awa == 8'h00) begin
          if (m_ws[0]) begin m_start = m_wd[0]; m_auto = m_wd[7]; end
        end else if (fmask(m_awa) != 0) begin
          nv = mget(m_awa);
          for (int b = 0; b < 4; b++) if (m_ws[b]) nv[b*8 +: 8] = m_wd[b*8 +: 8];
          mreg[int'(m_awa)] = nv & fmask(m_awa);
        end
      end
      if (eng_done) m_done = 1; else if (arf && araddr == 8'h00) m_done = 0;
      if (pkt_upd) m_vld = 1; else if (arf && araddr == 8'h50) m_vld = 0;
      if (commit) begin m_b = 1; m_awf = 0; m_wf = 0; end
      else if (m_b && bready) m_b = 0;
      if (awf) begin m_awf = 1; m_awa = awaddr; end
      if (wf) begin m_wf = 1; m_wd = wdata; m_ws = wstrb; end
      if (arf) m_r = 1; else if (m_r && rready) m_r = 0;
    end
  end

  function automatic string rtag(logic [7:0] a);
    if (a == 8'h00) return "R8 R9 control read";
    if (a == 8'h48 || a == 8'h50) return "R10 count read";
    if (a == 8'h54) return "R11 stat read";
    if (fmask(a) != 0) return "R3 config read";
    return "R12 unmapped read";
  endfunction

  always @(negedge clk) if (!rst && !finished) begin
    cmp("R2 awready", awready, !m_awf && !m_b);
    cmp("R2 wready", wready, !m_wf && !m_b);
    cmp("R2 bvalid", bvalid, m_b);
    if (bvalid) cmp("R2 bresp", bresp, 0);
    cmp("R12 arready", arready, !m_r);
    cmp("R12 rvalid", rvalid, m_r);
    if (rvalid) begin cmp(rtag(m_ra), rdata, m_rd); cmp("R12 rresp", rresp, 0); end
    cmp("R5 R6 R7 eng_start", eng_start, m_start);
    cmp("R5 eng_autorestart", eng_autorestart, m_auto);
    cmp("R3 width", cfg_width, mget(8'h10) & 32'hFFFF);
    cmp("R3 height", cfg_height, mget(8'h18) & 32'hFFFF);
    cmp("R3 format", cfg_format, mget(8'h20) & 32'hFFFF);
    cmp("R3 pkts", cfg_ppl, mget(8'h28) & 32'hFF);
    cmp("R3 payload", cfg_plen, mget(8'h30) & 32'h7FF);
    cmp("R3 last", cfg_plast, mget(8'h38) & 32'h7FF);
    cmp("R3 bpc", cfg_bpc, mget(8'h40) & 32'h1F);
    cmp("R11 stat_clear", stat_clear, mget(8'h54) & 32'h1);
  end

  // ---------------- bus tasks ----------------
  task automatic put_aw(logic [7:0] a);
    awaddr = a; awvalid = 1;
    while (!awready) @(negedge clk);
    @(negedge clk); awvalid = 0;
  endtask

  task automatic put_w(logic [31:0] d, logic [3:0] s);
    wdata = d; wstrb = s; wvalid = 1;
    while (!wready) @(negedge clk);
    @(negedge clk); wvalid = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] s = 4'hF,
                    int order = 0, int bdly = 0);
    @(negedge clk);
    if (order == 0) fork put_aw(a); put_w(d, s); join
    else if (order == 1) begin put_aw(a); repeat (2) @(negedge clk); put_w(d, s); end
    else begin put_w(d, s); @(negedge clk); put_aw(a); end
    repeat (bdly) @(negedge clk);
    bready = 1;
    while (!bvalid) @(negedge clk);
    @(negedge clk); bready = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, input int rdly = 0);
    @(negedge clk);
    araddr = a; arvalid = 1;
    while (!arready) @(negedge clk);
    @(negedge clk); arvalid = 0;
    repeat (rdly) @(negedge clk);
    rready = 1;
    while (!rvalid) @(negedge clk);
    d = rdata;
    @(negedge clk); rready = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1; @(negedge clk); sig = 0;
  endtask

  task automatic report();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cmp("R1 eng_start", eng_start, 0);
    cmp("R1 width", cfg_width, 0);
    cmp("R1 awready", awready, 1);
    cmp("R1 bvalid", bvalid, 0);
    rst = 0;
    rd(8'h00, d); cmp("R1 control", d, 0);
    rd(8'h10, d); cmp("R1 width reg", d, 0);

    // R3 configuration round trip, R2 orders and response hold
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hABCD_0780, 4'hF, 0, 0);
    wr(8'h18, 32'h0000_0438, 4'hF, 1, 3);
    wr(8'h20, 32'h0000_0002, 4'hF, 2, 1);
    wr(8'h28, 32'hFFFF_FF05, 4'hF, 1, 0);
    wr(8'h30, 32'hFFFF_F560, 4'hF, 2, 2);
    wr(8'h38, 32'h0000_0120, 4'hF, 0, 0);
    wr(8'h40, 32'hFFFF_FFEA, 4'hF, 0, 4);
    rd(8'h10, d, 2); cmp("R3 width upper bits zero", d, 32'h0780);
    rd(8'h28, d);    cmp("R3 packets field", d, 32'h05);
    rd(8'h30, d);    cmp("R3 payload field", d, 32'h560);
    rd(8'h40, d);    cmp("R3 bpc field", d, 32'h0A);

    // R4 byte strobes
    wr(8'h10, 32'hAAAA_1234, 4'b0001);
    rd(8'h10, d); cmp("R4 low byte only", d, 32'h0734);
    wr(8'h10, 32'h0000_5600, 4'b0010, 2);
    rd(8'h10, d); cmp("R4 high byte only", d, 32'h5634);

    // R12 ignored writes
    wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0081, 4'b0010);
    cmp("R12 strobe-less control write", eng_start, 0);
    rd(8'h04, d); cmp("R12 unmapped reads zero", d, 0);
    rd(8'hFC, d); cmp("R12 unmapped high", d, 0);

    // R5 R7 start sequence with auto-restart
    wr(8'h00, 32'h80);
    cmp("R5 auto set", eng_autorestart, 1);
    wr(8'h00, 32'h81);
    cmp("R5 start set", eng_start, 1);
    pulse(eng_ready);
    cmp("R7 start rearmed", eng_start, 1);
    pulse(eng_ready);
    cmp("R7 start still set", eng_start, 1);

    // R6 single shot
    wr(8'h00, 32'h01);
    pulse(eng_ready);
    cmp("R6 start cleared", eng_start, 0);

    // R8 done flag
    pulse(eng_done);
    rd(8'h00, d); cmp("R8 done set", d[1], 1);
    rd(8'h00, d); cmp("R8 done cleared by read", d[1], 0);

    // R9 status levels
    @(negedge clk); eng_idle = 1; eng_ready = 1;
    rd(8'h00, d); cmp("R9 idle and ready", d, 32'h0C);
    @(negedge clk); eng_idle = 0;
    rd(8'h00, d); cmp("R9 ready only", d, 32'h08);
    @(negedge clk); eng_ready = 0;

    // R10 packet count and valid flag
    @(negedge clk); pkt_count = 32'hDEAD_0123;
    pulse(pkt_upd);
    rd(8'h50, d); cmp("R10 valid set", d, 1);
    rd(8'h50, d); cmp("R10 valid cleared", d, 0);
    rd(8'h48, d); cmp("R10 count", d, 32'hDEAD_0123);

    // R11 statistics reset level
    wr(8'h54, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    cmp("R11 stat_clear holds", stat_clear, 1);
    rd(8'h54, d); cmp("R11 reads one", d, 1);
    wr(8'h54, 32'h0);
    cmp("R11 stat_clear released", stat_clear, 0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule